// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

The block turns a stream of stereo sample pairs into a single serial data line for an audio receiver. Each pair holds a left and a right two's-complement word. The words go out most significant bit first, one bit per serial-clock period. Two framings are supported. In left-justified framing the word starts right at the word-select edge. In I2S framing the word starts one bit period later, and the word-select polarity is the opposite. All logic runs on one fast system clock `clk`, and the serial clock and word select are treated as slow strobes of it.

In master mode the block makes its own serial clock and word select. The serial clock runs at 64 periods per frame, with 32 bit slots for each channel. In slave mode it follows an external serial clock and word select through a synchroniser. In that mode it can also be told that only 32 bit clocks come per frame, and it then sends only the upper 16 bits of each word. The bits that change on the serial line do so right after a falling serial-clock edge has been seen. Every bit slot after the last data bit of a channel carries a zero.

Samples arrive over a valid/ready interface into a one-pair holding register. The pair being sent is reloaded from that register at the start of each left-channel half frame. `in_ready` is high exactly when the holding register is empty. A producer that has `in_valid` high while `in_ready` is low must keep its data stable until it is accepted. If no new pair has arrived by the time a left half frame starts, the previous pair is sent again. The mode and format inputs are static configuration, and they are to be changed only while reset is asserted.

Top module: `aud_stereo_tx`

## Requirements
- R1: While `rst_n` is low, `sdto`, `sclk_o` and `lrck_o` are 0 and `in_ready` is 1.
- R2: In master mode, `sclk_o` toggles every HALF_DIV clocks, so a falling edge comes every 2*HALF_DIV clocks. `lrck_o` changes only in the clock where `sclk_o` falls, and it changes once every 32 falling edges.
- R3: `sdto` changes only one clock after a falling serial-clock edge has been processed. In master mode that is the same clock edge on which `sclk_o` falls.
- R4: With `fmt_i2s`=0, word select 1 marks the left channel. Slot 0 is the first falling edge after a word-select change, and it carries bit DATA_W-1. Slot n carries bit DATA_W-1-n. Every slot from DATA_W on carries 0.
- R5: With `fmt_i2s`=1, word select 0 marks the left channel. Slot 0 carries 0, and slot n (n≥1) carries bit DATA_W-n. Every slot beyond DATA_W carries 0.
- R6: In slave mode (`master_en`=0), `sclk_o` and `lrck_o` stay 0. A falling edge on `sclk_i` shows up on `sdto` SYNC_STAGES+1 clocks later, and `lrck_i` is sampled along the same path.
- R7: In slave mode with `narrow_en`=1, only the upper NARROW_W bits of each word are sent, and the later slots carry 0. In master mode `narrow_en` has no effect.
- R8: The first serial-clock fall after reset only records the word-select level. Framing starts at the first later change of word select into the left-channel level. Until then `sdto` stays 0 and no pair is taken from the holding register.
- R9: At each left-channel start, a full holding register is moved into the sending pair and the register is emptied. If the register is empty, the previous pair is sent again. The pair sent before any transfer is all zeros.
- R10: A transfer happens on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the following clock, and it returns to 1 only after the held pair has been taken at a left-channel start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset and power-down |
| master_en | input | 1 | 1: generate serial clock and word select; 0: follow external ones |
| fmt_i2s | input | 1 | 0: left-justified framing; 1: I2S framing |
| narrow_en | input | 1 | Slave only: 32 bit clocks per frame, send upper NARROW_W bits |
| sclk_i | input | 1 | External serial clock (slave mode) |
| lrck_i | input | 1 | External word select (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode, else 0) |
| lrck_o | output | 1 | Generated word select (master mode, else 0) |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Holding register empty |
| in_left | input | DATA_W | Left-channel sample |
| in_right | input | DATA_W | Right-channel sample |
| sdto | output | 1 | Serial data output |

## Verification
The bench builds the block with its default parameters: 24-bit words, 16-bit narrow words, a serial-clock half period of two system clocks and a two-stage synchroniser. With a four-clock bit period, a full 64-slot frame takes 256 clocks, so each run covers several frames. Those frames include the partial first half frame, the reloads of new pairs and the repeats of an old pair. In slave mode the bench drives word-select rates of 64, 48 and 32 bit clocks per frame. The slave path then has a latency of three clocks, which the reference model applies to the bench's own serial-clock and word-select waveforms.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } fmt_e;

  // One processed serial-clock falling edge and the word-select level seen with it.
  typedef struct packed {
    logic fall;
    logic lr;
  } bit_evt_t;

  // Left-justified: high word select is left; I2S: low word select is left.
  function automatic logic lr_is_left(logic lr, fmt_e fmt);
    return (fmt == FMT_I2S) ? ~lr : lr;
  endfunction

  function automatic int msb_delay(fmt_e fmt);
    return (fmt == FMT_I2S) ? 1 : 0;
  endfunction

endpackage

// File: rtl/aud_tx_master_clk.sv
module aud_tx_master_clk
  import aud_tx_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int SLOTS_HALF = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  output logic     sclk,
  output logic     lrck,
  output bit_evt_t evt
);
  localparam int DIV_W  = $clog2(HALF_DIV + 1);
  localparam int SLOT_W = $clog2(SLOTS_HALF);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS_HALF - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] cnt_q;
  logic              sclk_q, lrck_q;
  logic              tick, last_slot;

  assign tick      = en && (div_q == DIV_LAST);
  assign last_slot = (cnt_q == SLOT_LAST);
  assign evt.fall  = tick & sclk_q;
  assign evt.lr    = last_slot ? ~lrck_q : lrck_q;
  assign sclk      = sclk_q;
  assign lrck      = lrck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
      lrck_q <= 1'b0;
      cnt_q  <= SLOT_LAST;
    end else if (en) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) sclk_q <= ~sclk_q;
      if (evt.fall) begin
        lrck_q <= evt.lr;
        cnt_q  <= last_slot ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_tx_slave_sync.sv
module aud_tx_slave_sync
  import aud_tx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     sclk_in,
  input  logic     lrck_in,
  output bit_evt_t evt
);
  logic [STAGES-1:0] sck_s, lr_s;
  logic              sck_last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sck_s[g] <= 1'b0;
        lr_s[g]  <= 1'b0;
      end else begin
        sck_s[g] <= (g == 0) ? sclk_in : sck_s[(g == 0) ? 0 : g - 1];
        lr_s[g]  <= (g == 0) ? lrck_in : lr_s[(g == 0) ? 0 : g - 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b0;
    else        sck_last <= sck_s[STAGES-1];
  end

  assign evt.fall = en & sck_last & ~sck_s[STAGES-1];
  assign evt.lr   = lr_s[STAGES-1];
endmodule

// File: rtl/aud_tx_pair_buf.sv
module aud_tx_pair_buf #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic              take,
  output logic [DATA_W-1:0] word_l,
  output logic [DATA_W-1:0] word_r
);
  logic [DATA_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic              hold_full, reload, accept;

  assign in_ready = ~hold_full;
  assign accept   = in_valid & ~hold_full;
  assign reload   = take & hold_full;
  // The pair for the slot that starts the left half comes straight from the holding register.
  assign word_l   = reload ? hold_l : cur_l;
  assign word_r   = reload ? hold_r : cur_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
    end else if (reload) begin
      cur_l     <= hold_l;
      cur_r     <= hold_r;
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_l    <= in_left;
      hold_r    <= in_right;
      hold_full <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int SLOT_MAX = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bit_evt_t          evt,
  input  fmt_e              fmt,
  input  logic              narrow,
  input  logic [DATA_W-1:0] word_l,
  input  logic [DATA_W-1:0] word_r,
  output logic              take,
  output logic              started,
  output logic              sdto
);
  localparam int SLOT_W = $clog2(SLOT_MAX + 1);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(SLOT_MAX);

  logic              primed_q, lr_prev_q, started_q, sdto_q;
  logic [SLOT_W-1:0] slot_q, slot_now;
  logic              side_chg, left_now, run_now, bit_now;
  logic [DATA_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  int                k, wlen;

  assign side_chg = evt.fall & primed_q & (evt.lr != lr_prev_q);
  assign left_now = lr_is_left(evt.lr, fmt);
  assign take     = side_chg & left_now;
  assign run_now  = started_q | take;
  assign slot_now = side_chg ? '0 : ((slot_q == SLOT_TOP) ? slot_q : slot_q + 1'b1);
  assign word     = left_now ? word_l : word_r;

  always_comb begin
    k       = int'(slot_now) - msb_delay(fmt);
    wlen    = narrow ? NARROW_W : DATA_W;
    idx     = '0;
    bit_now = 1'b0;
    if (run_now && k >= 0 && k < wlen) begin
      idx     = IDX_W'(DATA_W - 1 - k);
      bit_now = word[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      lr_prev_q <= 1'b0;
      started_q <= 1'b0;
      slot_q    <= '0;
      sdto_q    <= 1'b0;
    end else if (evt.fall) begin
      lr_prev_q <= evt.lr;
      if (!primed_q) begin
        primed_q <= 1'b1;
      end else begin
        slot_q    <= slot_now;
        started_q <= run_now;
        sdto_q    <= bit_now;
      end
    end
  end

  assign started = started_q;
  assign sdto    = sdto_q;
endmodule

// File: rtl/aud_stereo_tx.sv
module aud_stereo_tx
  import aud_tx_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int NARROW_W    = 16,
  parameter int HALF_DIV    = 2,
  parameter int SLOTS_HALF  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_MAX    = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              fmt_i2s,
  input  logic              narrow_en,
  input  logic              sclk_i,
  input  logic              lrck_i,
  output logic              sclk_o,
  output logic              lrck_o,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              sdto
);
  bit_evt_t          m_evt, s_evt, evt;
  logic              m_sclk, m_lrck;
  logic              take, frm_started, fall_evt, narrow_eff;
  logic [DATA_W-1:0] word_l, word_r;
  fmt_e              fmt;

  assign fmt        = fmt_e'(fmt_i2s);
  assign narrow_eff = narrow_en & ~master_en;

  aud_tx_master_clk #(.HALF_DIV(HALF_DIV), .SLOTS_HALF(SLOTS_HALF)) u_mclk (
    .clk(clk), .rst_n(rst_n), .en(master_en),
    .sclk(m_sclk), .lrck(m_lrck), .evt(m_evt)
  );

  aud_tx_slave_sync #(.STAGES(SYNC_STAGES)) u_ssync (
    .clk(clk), .rst_n(rst_n), .en(~master_en),
    .sclk_in(sclk_i), .lrck_in(lrck_i), .evt(s_evt)
  );

  assign evt      = master_en ? m_evt : s_evt;
  assign fall_evt = evt.fall;
  assign sclk_o   = master_en & m_sclk;
  assign lrck_o   = master_en & m_lrck;

  aud_tx_pair_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .take(take), .word_l(word_l), .word_r(word_r)
  );

  aud_tx_framer #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .SLOT_MAX(SLOT_MAX)) u_frm (
    .clk(clk), .rst_n(rst_n), .evt(evt), .fmt(fmt), .narrow(narrow_eff),
    .word_l(word_l), .word_r(word_r),
    .take(take), .started(frm_started), .sdto(sdto)
  );
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic sclk_o,
  input logic lrck_o,
  input logic sdto,
  input logic in_valid,
  input logic in_ready,
  input logic fall_evt,
  input logic started
);
  AST_LRCK_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !$stable(lrck_o)) |-> $fell(sclk_o)); // R2

  AST_SDTO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdto) |-> $past(fall_evt)); // R3

  AST_SLAVE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!sclk_o && !lrck_o)); // R6

  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !sdto); // R8

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R10
endmodule

bind aud_stereo_tx aud_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en),
  .sclk_o(sclk_o), .lrck_o(lrck_o), .sdto(sdto),
  .in_valid(in_valid), .in_ready(in_ready),
  .fall_evt(fall_evt), .started(frm_started)
);

// File: tb/tb_aud_stereo_tx.sv
`timescale 1ns/1ps
module tb_aud_stereo_tx;
  localparam int DW = 24, NW = 16, HALF_DIV = 2, SYNC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, master_en = 1'b1, fmt_i2s = 1'b0, narrow_en = 1'b0;
  logic          sclk_i = 1'b0, lrck_i = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic          sclk_o, lrck_o, in_ready, sdto;

  aud_stereo_tx dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .fmt_i2s(fmt_i2s),
    .narrow_en(narrow_en), .sclk_i(sclk_i), .lrck_i(lrck_i),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .sdto(sdto)
  );

  int    n_checks = 0, n_fail = 0;
  string cur_tag = "R1";

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped at every falling clk edge.
  bit            m_primed, m_lrprev, m_started, m_full, m_pend, exp_sdto;
  int            m_slot;
  logic [DW-1:0] m_cur_l, m_cur_r, m_hold_l, m_hold_r, m_pend_l, m_pend_r;
  bit            hs[5], hl[5];
  int            clk_since_fall, falls_since_lr;
  bit            seen_fall, seen_lr, prev_lrck_o;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_primed = 0; m_lrprev = 0; m_started = 0; m_full = 0; m_pend = 0; exp_sdto = 0;
      m_slot = 0; m_cur_l = '0; m_cur_r = '0; m_hold_l = '0; m_hold_r = '0;
      for (int i = 0; i < 5; i++) begin hs[i] = 0; hl[i] = 0; end
      clk_since_fall = 0; falls_since_lr = 0; seen_fall = 0; seen_lr = 0; prev_lrck_o = 0;
    end else begin
      int lat, kk, wl;
      bit fall, lr, left;
      logic [DW-1:0] w;
      for (int i = 4; i > 0; i--) begin hs[i] = hs[i-1]; hl[i] = hl[i-1]; end
      hs[0] = master_en ? sclk_o : sclk_i;
      hl[0] = master_en ? lrck_o : lrck_i;
      lat  = master_en ? 0 : SYNC + 1;
      fall = hs[lat+1] && !hs[lat];
      lr   = hl[lat];
      if (fall) begin
        if (!m_primed) begin
          m_primed = 1;
        end else begin
          left = fmt_i2s ? !lr : lr;
          if (lr != m_lrprev) begin
            m_slot = 0;
            if (left) begin
              m_started = 1;
              if (m_full) begin m_cur_l = m_hold_l; m_cur_r = m_hold_r; m_full = 0; end
            end
          end else if (m_slot < 63) m_slot++;
          kk = m_slot - (fmt_i2s ? 1 : 0);
          wl = (narrow_en && !master_en) ? NW : DW;
          w  = left ? m_cur_l : m_cur_r;
          exp_sdto = m_started && kk >= 0 && kk < wl ? w[DW-1-kk] : 1'b0;
        end
        m_lrprev = lr;
      end
      if (m_pend) begin m_hold_l = m_pend_l; m_hold_r = m_pend_r; m_full = 1; m_pend = 0; end
      check(sdto === exp_sdto, cur_tag, "sdto", sdto, exp_sdto);
      check(in_ready === !m_full, "R10", "in_ready", in_ready, !m_full);
      if (in_valid && in_ready) begin m_pend = 1; m_pend_l = in_left; m_pend_r = in_right; end
      if (!master_en) begin
        check(!sclk_o && !lrck_o, "R6", "sclk_o/lrck_o in slave", {sclk_o, lrck_o}, 0);
      end else begin
        clk_since_fall++;
        if (fall) begin
          if (seen_fall) check(clk_since_fall == 2*HALF_DIV, "R2", "clocks per sclk_o period",
                               clk_since_fall, 2*HALF_DIV);
          seen_fall = 1; clk_since_fall = 0; falls_since_lr++;
        end
        if (lrck_o != prev_lrck_o) begin
          check(fall, "R2", "lrck_o moves with sclk_o fall", fall, 1);
          if (seen_lr) check(falls_since_lr == 32, "R2", "falls per half frame", falls_since_lr, 32);
          seen_lr = 1; falls_since_lr = 0;
        end
        prev_lrck_o = lrck_o;
      end
    end
  end

  task automatic drive_slave(bit f, int slots, int frames);
    bit left_lvl = !f;
    for (int fr = 0; fr < frames; fr++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < slots; s++) begin
          @(posedge clk); #1;
          sclk_i = 1'b0;
          if (s == 0) lrck_i = (h == 0) ? left_lvl : !left_lvl;
          repeat (3) @(posedge clk);
          #1 sclk_i = 1'b1;
          repeat (2) @(posedge clk);
        end
  endtask

  task automatic send(logic [DW-1:0] l, logic [DW-1:0] r);
    @(posedge clk); #1;
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_cfg(bit m, bit f, bit nar, int slots, int frames, string tag, logic [DW-1:0] seed);
    rst_n = 1'b0; master_en = m; fmt_i2s = f; narrow_en = nar;
    sclk_i = 1'b0; lrck_i = !f; in_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sdto === 1'b0 && sclk_o === 1'b0 && lrck_o === 1'b0, "R1", "outputs in reset",
          {sdto, sclk_o, lrck_o}, 0);
    check(in_ready === 1'b1, "R1", "in_ready in reset", in_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    cur_tag = tag;
    fork
      begin
        if (!m) drive_slave(f, slots, frames);
        else repeat (frames * 64 * 2 * HALF_DIV) @(posedge clk);
      end
      begin
        send(24'hA5C3F1 ^ seed, 24'h5A3C0E ^ seed);
        send(24'h800001 ^ seed, 24'h7FFFFE ^ seed);
        send(24'hFFFF00 ^ seed, 24'h0000FF ^ seed); // later frames repeat this pair (R9)
      end
    join
    cur_tag = "R1";
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    run_cfg(1, 0, 1, 32, 7, "R3/R4/R7/R8/R9 master left-justified", 24'h000000);
    run_cfg(1, 1, 0, 32, 7, "R3/R5/R9 master I2S", 24'h13579B);
    run_cfg(0, 0, 0, 32, 7, "R4/R6/R8 slave left-justified 64fs", 24'h2468AC);
    run_cfg(0, 1, 0, 32, 7, "R5/R6/R8 slave I2S 64fs", 24'h0F0F0F);
    run_cfg(0, 0, 0, 24, 7, "R4/R6 slave left-justified 48fs", 24'h336699);
    run_cfg(0, 0, 1, 16, 8, "R6/R7 slave narrow 32fs", 24'hC0FFEE);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule